// File: doc/BRIEF.md
# Timed Register Write-Protection Lock

This block decides whether a bus write may reach a protected bank of registers. It watches every write strobe, with its address and data. It drives a write-enable qualifier that the protected registers AND into their own write enables. It also reports whether protection is currently on. The registers themselves are not part of the block.

After power-on reset the bank is open. It closes by itself after a fixed number of one-second ticks. Software opens it again by writing a two-value key to a dedicated lock address. It then stays open for a short window of ticks and closes again by itself. Software can close it at any moment with a lock command. A write aimed at the protected range while the bank is closed is discarded. Such a write raises a sticky error flag, and software clears that flag by writing a one.

Windows count whole ticks of the 1 Hz input, starting from zero at the moment the bank opens. The bank therefore closes on the N-th tick after it opened. In real time that is between N-1 and N seconds, depending on the phase of the tick.

Top module: `wprot_gate`

## Requirements
- R1: After reset, `locked` is 0 and `bus_err` is 0, and the power-on window (PO_SECS ticks, default 15) is running.
- R2: With no software action after reset, `locked` rises on the clock edge that samples the PO_SECS-th `sec_tick` and not earlier.
- R3: Two consecutive writes to the lock address (LOCK_ADDR, default 0x00) with data KEY1 (default 0x00) and then KEY2 (default 0x40) clear `locked` on the clock edge of the second write.
- R4: Any other sequence of writes to the lock address leaves a locked bank locked. This includes KEY2 alone, KEY2 before KEY1, and KEY1 followed by a different value and then KEY2.
- R5: After a key unlock, `locked` rises on the clock edge that samples the UL_SECS-th `sec_tick` (default 2). A new key unlock while the bank is open restarts that window from zero.
- R6: A write of LOCK_CMD (default 0x80) to the lock address sets `locked` on that clock edge and stops any running window.
- R7: `prot_wr_ok` is high in a cycle exactly when `wr_en` is high, `wr_addr` is at or above PROT_BASE (default 0x10), and the bank is unlocked.
- R8: A write to an address at or above PROT_BASE while `locked` is 1 sets `bus_err` on that clock edge. Writes below PROT_BASE never set it.
- R9: A write to the error address (ERR_ADDR, default 0x01) with data bit 0 equal to 1 clears `bus_err`. With data bit 0 equal to 0 that write leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| sec_tick | input | 1 | One-cycle pulse once per second |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | ADDR_W | Bus write address |
| wr_data | input | DATA_W | Bus write data |
| prot_wr_ok | output | 1 | Write-enable qualifier for the protected bank |
| locked | output | 1 | Protection status, 1 when writes are blocked |
| bus_err | output | 1 | Sticky flag for a write dropped by the lock |

## Verification
The bench counts ticks up to the exact edge on which each window closes, for both the power-on and the software window. A counter that is off by one closes a tick early or late, and the first check on the wrong side catches it. Broken key sequences go after a detector that only matches the last value, which would unlock on KEY2 after any earlier write. A second key unlock inside an open window shows whether a design fails to restart its count and closes early. The error flag is written with bit 0 clear, which would wrongly clear a flag that decodes the address alone. A write below the protected range while locked would falsely raise the flag if the range compare were dropped.

// File: rtl/wprot_pkg.sv
package wprot_pkg;
  // Which auto-lock window the timer is measuring
  typedef enum logic {
    WIN_POWERON = 1'b0,
    WIN_SOFT    = 1'b1
  } win_sel_e;
endpackage

// File: rtl/wprot_key_seq.sv
module wprot_key_seq #(
  parameter int          DATA_W = 8,
  parameter logic [DATA_W-1:0] KEY1 = 8'h00,
  parameter logic [DATA_W-1:0] KEY2 = 8'h40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lock_wr,
  input  logic [DATA_W-1:0] lock_data,
  output logic              unlock_req
);
  logic armed_q, armed_d;

  // Any write to the lock register re-arms only on KEY1; all else disarms
  always_comb begin
    armed_d = armed_q;
    if (lock_wr) armed_d = (lock_data == KEY1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_d;
  end

  assign unlock_req = lock_wr && armed_q && (lock_data == KEY2);
endmodule

// File: rtl/wprot_win_timer.sv
module wprot_win_timer
  import wprot_pkg::*;
#(
  parameter int PO_SECS = 15,
  parameter int UL_SECS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sec_tick,
  input  logic run,
  input  logic restart,
  output logic expire
);
  localparam int MAXW  = (PO_SECS > UL_SECS) ? PO_SECS : UL_SECS;
  localparam int CNT_W = $clog2(MAXW + 1);
  localparam logic [CNT_W-1:0] PO_LAST = CNT_W'(PO_SECS - 1);
  localparam logic [CNT_W-1:0] UL_LAST = CNT_W'(UL_SECS - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  win_sel_e         win_q, win_d;
  logic             cnt_en, last;

  always_comb begin
    last   = (win_q == WIN_SOFT) ? (cnt_q == UL_LAST) : (cnt_q == PO_LAST);
    expire = run && sec_tick && last && !restart;
    cnt_en = restart || (run && sec_tick);
    cnt_d  = restart ? '0 : cnt_q + 1'b1;
    win_d  = restart ? WIN_SOFT : win_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      win_q <= WIN_POWERON;
    end else begin
      if (cnt_en)  cnt_q <= cnt_d;
      if (restart) win_q <= win_d;
    end
  end
endmodule

// File: rtl/wprot_gate.sv
module wprot_gate #(
  parameter int                ADDR_W    = 8,
  parameter int                DATA_W    = 8,
  parameter int                PO_SECS   = 15,
  parameter int                UL_SECS   = 2,
  parameter logic [ADDR_W-1:0] LOCK_ADDR = 8'h00,
  parameter logic [ADDR_W-1:0] ERR_ADDR  = 8'h01,
  parameter logic [ADDR_W-1:0] PROT_BASE = 8'h10,
  parameter logic [DATA_W-1:0] KEY1      = 8'h00,
  parameter logic [DATA_W-1:0] KEY2      = 8'h40,
  parameter logic [DATA_W-1:0] LOCK_CMD  = 8'h80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              prot_wr_ok,
  output logic              locked,
  output logic              bus_err
);
  logic lock_wr, lock_cmd, err_wr, prot_hit;
  logic unlock_req, expire;
  logic locked_q, locked_d, err_q, err_d;

  assign lock_wr  = wr_en && (wr_addr == LOCK_ADDR);
  assign lock_cmd = lock_wr && (wr_data == LOCK_CMD);
  assign err_wr   = wr_en && (wr_addr == ERR_ADDR);
  assign prot_hit = wr_en && (wr_addr >= PROT_BASE);

  wprot_key_seq #(
    .DATA_W (DATA_W),
    .KEY1   (KEY1),
    .KEY2   (KEY2)
  ) u_key (
    .clk        (clk),
    .rst_n      (rst_n),
    .lock_wr    (lock_wr),
    .lock_data  (wr_data),
    .unlock_req (unlock_req)
  );

  wprot_win_timer #(
    .PO_SECS (PO_SECS),
    .UL_SECS (UL_SECS)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .sec_tick (sec_tick),
    .run      (!locked_q),
    .restart  (unlock_req),
    .expire   (expire)
  );

  // Lock state: command beats key beats timer
  always_comb begin
    locked_d = locked_q;
    if (lock_cmd)        locked_d = 1'b1;
    else if (unlock_req) locked_d = 1'b0;
    else if (expire)     locked_d = 1'b1;
  end

  // Sticky error: set by a blocked write, cleared by write-one
  always_comb begin
    err_d = err_q;
    if (prot_hit && locked_q)     err_d = 1'b1;
    else if (err_wr && wr_data[0]) err_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      locked_q <= locked_d;
      err_q    <= err_d;
    end
  end

  assign prot_wr_ok = prot_hit && !locked_q;
  assign locked     = locked_q;
  assign bus_err    = err_q;
endmodule

// File: rtl/wprot_gate_chk.sv
module wprot_gate_chk #(
  parameter int                ADDR_W    = 8,
  parameter int                DATA_W    = 8,
  parameter int                PO_SECS   = 15,
  parameter int                UL_SECS   = 2,
  parameter logic [ADDR_W-1:0] LOCK_ADDR = 8'h00,
  parameter logic [ADDR_W-1:0] ERR_ADDR  = 8'h01,
  parameter logic [ADDR_W-1:0] PROT_BASE = 8'h10,
  parameter logic [DATA_W-1:0] KEY2      = 8'h40,
  parameter logic [DATA_W-1:0] LOCK_CMD  = 8'h80
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sec_tick,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              locked,
  input logic              bus_err
);
  localparam int MAXW = (PO_SECS > UL_SECS) ? PO_SECS : UL_SECS;
  localparam int TW   = $clog2(MAXW + 2);

  logic          key2_wr;
  logic [TW-1:0] open_ticks;

  assign key2_wr = wr_en && (wr_addr == LOCK_ADDR) && (wr_data == KEY2);

  // Ticks seen while open, cleared whenever the bank is locked or a key lands
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  open_ticks <= '0;
    else if (locked || key2_wr)  open_ticks <= '0;
    else if (sec_tick)           open_ticks <= open_ticks + 1'b1;
  end

  assert_window_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> (open_ticks < TW'(MAXW)));

  assert_lock_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == LOCK_ADDR && wr_data == LOCK_CMD) |=> locked);

  assert_stay_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !key2_wr) |=> locked);

  assert_unlock_by_key_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> $past(key2_wr));

  assert_err_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_err) |-> $past(locked && wr_en && wr_addr >= PROT_BASE));

  assert_err_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_err && wr_en && wr_addr == ERR_ADDR && wr_data[0]) |=> !bus_err);
endmodule

bind wprot_gate wprot_gate_chk #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .PO_SECS   (PO_SECS),
  .UL_SECS   (UL_SECS),
  .LOCK_ADDR (LOCK_ADDR),
  .ERR_ADDR  (ERR_ADDR),
  .PROT_BASE (PROT_BASE),
  .KEY2      (KEY2),
  .LOCK_CMD  (LOCK_CMD)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sec_tick (sec_tick),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data),
  .locked   (locked),
  .bus_err  (bus_err)
);

// File: tb/wprot_gate_bench.sv
module wprot_gate_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       sec_tick;
  logic       wr_en;
  logic [7:0] wr_addr;
  logic [7:0] wr_data;
  logic       prot_wr_ok, locked, bus_err;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;
  logic seen_ok;

  always #10 clk = ~clk;

  wprot_gate u_wprot_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .sec_tick   (sec_tick),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .prot_wr_ok (prot_wr_ok),
    .locked     (locked),
    .bus_err    (bus_err)
  );

  // Vector: {op(0=write,1=tick), addr, data, exp_locked, exp_err}
  localparam int NV = 18;
  localparam logic [18:0] VEC [NV] = '{
    {1'b0, 8'h20, 8'h55, 1'b1, 1'b1},  // R8 blocked write
    {1'b0, 8'h01, 8'h01, 1'b1, 1'b0},  // R9 clear
    {1'b0, 8'h00, 8'h40, 1'b1, 1'b0},  // R4 KEY2 alone
    {1'b0, 8'h00, 8'h00, 1'b1, 1'b0},
    {1'b0, 8'h00, 8'h12, 1'b1, 1'b0},  // R4 sequence broken
    {1'b0, 8'h00, 8'h40, 1'b1, 1'b0},  // R4 still locked
    {1'b0, 8'h00, 8'h00, 1'b1, 1'b0},
    {1'b0, 8'h00, 8'h40, 1'b0, 1'b0},  // R3 unlock
    {1'b0, 8'h20, 8'h33, 1'b0, 1'b0},  // R8 no error when open
    {1'b1, 8'h00, 8'h00, 1'b0, 1'b0},  // R5 tick 1
    {1'b1, 8'h00, 8'h00, 1'b1, 1'b0},  // R5 tick 2 locks
    {1'b0, 8'h00, 8'h00, 1'b1, 1'b0},
    {1'b0, 8'h00, 8'h40, 1'b0, 1'b0},  // R3 unlock again
    {1'b0, 8'h00, 8'h80, 1'b1, 1'b0},  // R6 lock command
    {1'b1, 8'h00, 8'h00, 1'b1, 1'b0},  // R6 timer cancelled
    {1'b0, 8'h30, 8'h01, 1'b1, 1'b1},  // R8 error again
    {1'b0, 8'h01, 8'h00, 1'b1, 1'b1},  // R9 bit0 clear has no effect
    {1'b0, 8'h01, 8'h03, 1'b1, 1'b0}   // R9 clear
  };

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  // Drive at negedge, capture comb qualifier mid-cycle, sample after edge
  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    #1 seen_ok = prot_wr_ok;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk);
    sec_tick = 1'b1;
    @(negedge clk);
    sec_tick = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sec_tick = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 locked after reset", locked, 1'b0);
    chk("R1 bus_err after reset", bus_err, 1'b0);

    // R7 qualifier while open, protected and unprotected targets
    wr(8'h20, 8'hAA);
    chk("R7 open protected write", seen_ok, 1'b1);
    wr(8'h05, 8'hAA);
    chk("R7 unprotected write", seen_ok, 1'b0);

    // R2 power-on window: open through 14 ticks, locks on the 15th
    for (int i = 1; i < 15; i++) tick();
    chk("R2 open after 14 ticks", locked, 1'b0);
    tick();
    chk("R2 locked on 15th tick", locked, 1'b1);

    // R7 qualifier low while locked; unprotected write leaves flag clear (R8)
    wr(8'h20, 8'h11);
    chk("R7 locked protected write", seen_ok, 1'b0);
    chk("R8 blocked write sets flag", bus_err, 1'b1);
    wr(8'h01, 8'h01);
    wr(8'h07, 8'h11);
    chk("R8 unprotected write while locked", bus_err, 1'b0);

    for (int v = 0; v < NV; v++) begin
      if (VEC[v][18]) tick();
      else            wr(VEC[v][17:10], VEC[v][9:2]);
      chk($sformatf("vector %0d locked (R3 R4 R5 R6)", v), locked, VEC[v][1]);
      chk($sformatf("vector %0d bus_err (R8 R9)", v), bus_err, VEC[v][0]);
    end

    // R5 re-unlock inside window restarts count
    wr(8'h00, 8'h00); wr(8'h00, 8'h40);
    tick();
    wr(8'h00, 8'h00); wr(8'h00, 8'h40);
    tick();
    chk("R5 restarted window still open", locked, 1'b0);
    tick();
    chk("R5 restarted window closes", locked, 1'b1);

    // R1 reset reopens a locked bank and clears the flag
    wr(8'h40, 8'h00);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reopened by reset", locked, 1'b0);
    chk("R1 flag cleared by reset", bus_err, 1'b0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule